// File: doc/BRIEF.md
# Prescaled reloading interval timer

A programmable interval timer for periodic event generation. Software sets a down-counter, a prescale value and a reload period through a small register write port and starts the timer with an enable bit in a control register. A prescaler divides the clock so that the down-counter moves once every `scale + 1` enabled cycles. When a prescaled tick finds the down-counter already at zero, the timer emits a one-cycle interrupt pulse and reloads the down-counter from the period register.

All registers can be read back through a combinational read port. The read port shows the live down-counter value. A write to the down-counter or to the scale register takes effect at once, which lets software retune a running timer.

Top module: `interval_timer`

## Requirements
- R1: After reset every register reads zero, the enable bit is clear and `irq_o` is low.
- R2: Register addresses: 0 is the down-counter (16 bits), 1 is the period (16 bits), 2 is the scale (bits 7:0; upper write bits are dropped and read as zero), 3 is control (bit 0 is the enable bit, other bits read zero). `rd_data_o` shows the register chosen by `rd_addr_i` in the same cycle.
- R3: While enabled, the down-counter steps once every `scale + 1` clock edges. The first step happens `scale + 1` edges after the edge that sets the enable bit.
- R4: A tick that finds the down-counter non-zero decrements it by one. A tick that finds it at zero reloads it from the period register. With counter value `c` at enable, the first interrupt follows `(c+1)*(scale+1)` edges after the enabling edge.
- R5: The interrupt is a pulse one cycle wide. It is high in the cycle right after the reloading edge, and in that cycle the down-counter reads the period value.
- R6: Later interrupts repeat every `(period+1)*(scale+1)` edges. A period of 0 gives an interrupt on every prescaled tick.
- R7: While the enable bit is clear, the down-counter and the prescaler hold their values and no interrupt is raised.
- R8: A write to the down-counter loads the new value on that edge and overrides any tick in the same cycle. This holds even while the timer is running.
- R9: A write to the scale register also restarts the prescaler from the written value. The next tick then comes `new_scale + 1` edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address for the write |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Register address for the read |
| rd_data_o | output | 16 | Read data (combinational) |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Writes land on the edge that samples the strobe. The interrupt appears after the edge on which the reloading tick happens, so its first rise is due `(c+1)*(scale+1)` edges after the enabling write edge, and later rises are due `(period+1)*(scale+1)` edges apart. The bench counts rising edges from the write edge and samples `irq_o` and the read port only at falling edges. Each interrupt must first show up on exactly the predicted edge count, never earlier. Reads are combinational and are taken a moment after the address changes.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_SCALE  = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SCL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [SCL_W-1:0]  scale_o,
  output logic              en_o,
  output logic              count_wr_o,
  output logic              scale_wr_o,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic [CNT_W-1:0] period_q;
  logic [SCL_W-1:0] scale_q;
  logic             en_q;

  assign count_wr_o = wr_en_i && (wr_addr_i == SEL_COUNT);
  assign scale_wr_o = wr_en_i && (wr_addr_i == SEL_SCALE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      scale_q  <= '0;
      en_q     <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        SEL_PERIOD: period_q <= wr_data_i;
        SEL_SCALE:  scale_q  <= wr_data_i[SCL_W-1:0];
        SEL_CTRL:   en_q     <= wr_data_i[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      SEL_COUNT:  rd_data_o = count_i;
      SEL_PERIOD: rd_data_o = period_q;
      SEL_SCALE:  rd_data_o = CNT_W'(scale_q);
      default:    rd_data_o = CNT_W'(en_q);
    endcase
  end

  assign period_o = period_q;
  assign scale_o  = scale_q;
  assign en_o     = en_q;
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [SCL_W-1:0] load_val_i,
  input  logic [SCL_W-1:0] scale_i,
  output logic [SCL_W-1:0] pre_o,
  output logic             tick_o
);
  logic [SCL_W-1:0] pre_q;

  // a restart on the expiring cycle swallows that tick
  assign tick_o = en_i && !load_i && (pre_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (load_i)      pre_q <= load_val_i;
    else if (en_i) begin
      if (pre_q == '0)    pre_q <= scale_i;
      else                pre_q <= pre_q - SCL_W'(1);
    end
  end

  assign pre_o = pre_q;
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             irq_q;
  logic             expire;

  assign expire = tick_i && !wr_i && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= expire;
      if (wr_i)        count_q <= wr_data_i;
      else if (tick_i) count_q <= (count_q == '0) ? period_i : count_q - CNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SCL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] count_q;
  logic [SCL_W-1:0] scale_q;
  logic [SCL_W-1:0] pre_q;
  logic             en_q;
  logic             count_wr;
  logic             scale_wr;
  logic             tick;

  timer_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .count_i    (count_q),
    .period_o   (period_q),
    .scale_o    (scale_q),
    .en_o       (en_q),
    .count_wr_o (count_wr),
    .scale_wr_o (scale_wr),
    .rd_data_o  (rd_data_o)
  );

  timer_prescaler #(.SCL_W(SCL_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .load_i     (scale_wr),
    .load_val_i (wr_data_i[SCL_W-1:0]),
    .scale_i    (scale_q),
    .pre_o      (pre_q),
    .tick_o     (tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_i      (count_wr),
    .wr_data_i (wr_data_i),
    .period_i  (period_q),
    .count_o   (count_q),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/timer_chk.sv
module timer_chk
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SCL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic              en_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  period_q,
  input logic [SCL_W-1:0]  pre_q,
  input logic              irq_o
);
  // R5
  irq_shows_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> count_q == $past(period_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_en_i) |=> ($stable(count_q) && $stable(pre_q)));

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_en_i) |=> !irq_o);

  // R4
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && count_q != '0) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) - CNT_W'(1)));

  // R9
  scale_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_SCALE) |=> pre_q == $past(wr_data_i[SCL_W-1:0]));

  // R8
  count_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_COUNT) |=> (count_q == $past(wr_data_i) && !irq_o));
endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .en_q      (en_q),
  .count_q   (count_q),
  .period_q  (period_q),
  .pre_q     (pre_q),
  .irq_o     (irq_o)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  localparam int LIMIT = 20000;
  // scale, count, period, first irq edge, repeat interval
  localparam int unsigned VEC [6][5] = '{
    '{  0,  0, 0,   1,   1},
    '{  0,  5, 3,   6,   4},
    '{  3,  2, 4,  12,  20},
    '{  1,  0, 0,   2,   2},
    '{255,  1, 1, 512, 512},
    '{  4, 10, 0,  55,   5}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  interval_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr_i = a;
    #1;
    d = int'(rd_data_o);
  endtask

  // edges after the last write edge until irq_o is seen at a falling edge
  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end while (!irq_o && n < LIMIT);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, v2, n;
    // R1 reset state
    #5;
    chk("R1 irq in reset", int'(irq_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg reset value", v, 0);
    end
    chk("R1 irq after reset", int'(irq_o), 0);

    // R2 readback and scale width
    wr(2'd1, 16'h1234); wr(2'd2, 16'h01AB); wr(2'd0, 16'hBEEF); wr(2'd3, 16'hFFFE);
    rd(2'd1, v); chk("R2 period readback", v, 'h1234);
    rd(2'd2, v); chk("R2 scale upper bits dropped", v, 'hAB);
    rd(2'd0, v); chk("R2 count readback", v, 'hBEEF);
    rd(2'd3, v); chk("R2 control only bit0", v, 0);

    // R3 R4 R5 R6 vector table
    for (int i = 0; i < 6; i++) begin
      wr(2'd3, 16'd0);
      wr(2'd2, 16'(VEC[i][0]));
      wr(2'd1, 16'(VEC[i][2]));
      wr(2'd0, 16'(VEC[i][1]));
      wr(2'd3, 16'd1);
      wait_irq(n);
      chk($sformatf("R4 R3 first irq vec%0d", i), n, int'(VEC[i][3]));
      rd(2'd0, v);
      chk($sformatf("R5 count at irq vec%0d", i), v, int'(VEC[i][2]));
      if (VEC[i][4] > 1) begin
        @(negedge clk_i);
        chk($sformatf("R5 pulse width vec%0d", i), int'(irq_o), 0);
        wait_irq(n);
        n = n + 1;
      end else begin
        wait_irq(n);
      end
      chk($sformatf("R6 interval vec%0d", i), n, int'(VEC[i][4]));
    end

    // R8 direct count write while running
    wr(2'd3, 16'd0);
    wr(2'd2, 16'd0); wr(2'd1, 16'd1000); wr(2'd0, 16'd1000);
    wr(2'd3, 16'd1);
    repeat (7) @(negedge clk_i);
    wr(2'd0, 16'd3);
    n = 0;
    while (!irq_o && n < LIMIT) begin
      @(posedge clk_i); n++; @(negedge clk_i);
    end
    chk("R8 irq after count write", n, 4);

    // R9 scale write restarts the prescaler
    wr(2'd3, 16'd0);
    wr(2'd2, 16'd9); wr(2'd1, 16'd100); wr(2'd0, 16'd0);
    wr(2'd3, 16'd1);
    repeat (3) @(negedge clk_i);
    wr(2'd2, 16'd3);
    n = 0;
    while (!irq_o && n < LIMIT) begin
      @(posedge clk_i); n++; @(negedge clk_i);
    end
    chk("R9 irq after scale restart", n, 4);

    // R7 disabled timer holds
    wr(2'd3, 16'd0);
    wr(2'd2, 16'd2); wr(2'd1, 16'd500); wr(2'd0, 16'd50);
    wr(2'd3, 16'd1);
    repeat (10) @(negedge clk_i);
    wr(2'd3, 16'd0);
    @(negedge clk_i);
    rd(2'd0, v);
    chk("R7 count moved while enabled", int'(v < 50), 1);
    n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      if (irq_o) n++;
    end
    rd(2'd0, v2);
    chk("R7 count held while disabled", v2, v);
    chk("R7 no irq while disabled", n, 0);

    // R7 zero count disabled never fires
    wr(2'd0, 16'd0);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (irq_o) n++;
    end
    chk("R7 zero count disabled silent", n, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule